// File: doc/BRIEF.md
# Cell Erasure Recovery Decoder for a Two-Dimensional Parity Product Code

The block takes one protected block of fixed-size network cells, a byte at a time. A block is a 6 × 6 grid of 53-byte cells, sent in row-major order. The top-left 5 × 5 sub-grid holds data. The last column holds the row parities, and the last row holds the column parities. The bottom-right cell is the parity of the parity cells. Each parity cell is the bytewise XOR of the other cells in its line. Any cell may arrive marked as lost.

Once the whole block is stored, the decoder runs passes over all 53 byte positions at once, alternating rows and columns. In each pass, every line that holds exactly one lost cell gets that cell rebuilt from the XOR of its other five cells. Parity cells are rebuilt too, so they can help later passes. Decoding stops when a row pass and a column pass in a row rebuild nothing, or when no lost cell is left.

The 25 data cells are then streamed out in row-major order, together with a flag that marks the block as not fully recovered. Lost data cells that could not be rebuilt are output as zero bytes.

Top module: `cell_erasure_decoder`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A block starts with a byte where in_valid and in_sob are both 1. That byte is cell 0, byte 0. Bytes accepted with in_sob at 0 while no block is open are ignored. Cell index is row*6+column, bytes 0..52 within each cell, and row 5 and column 5 carry parity. A byte is taken only when in_valid and in_ready are both 1.
- R3: The lost marker in_erased is sampled only on byte 0 of each cell. Its value on bytes 1..52 has no effect on the output.
- R4: A block with no lost cells is output unchanged, with out_fail at 0.
- R5: A lost cell, whether data or parity, that is alone in its row or its column is rebuilt exactly.
- R6: Lost cells that can only be reached through alternating row and column passes are rebuilt exactly. This includes cells reached through parity cells rebuilt in an earlier pass.
- R7: If any data cell stays lost after the passes, out_fail is 1 on every output byte of the block. Such cells are output as 0x00, and every other data cell is still correct.
- R8: The output has 25 data cells × 53 bytes, ordered row-major over the data grid, with out_valid held high without gaps. out_last is 1 only on the final byte.
- R9: in_ready is 0 from the acceptance of the final input byte until the cycle after out_last.
- R10: The first out_valid comes no more than 81 cycles after the final input byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Decoder can take an input byte |
| in_sob | input | 1 | First byte of a block |
| in_erased | input | 1 | Cell lost; sampled on byte 0 of each cell |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Recovered data byte |
| out_last | output | 1 | Final byte of the block |
| out_fail | output | 1 | Block has data cells that could not be rebuilt |

## Verification
Blocks are tried with no loss, which separates plain storage and ordering from repair. They are also tried with single losses in data and parity cells, which exercises the one-pass repair. Chained and staircase patterns follow: these are only solvable through several alternating passes, so a decoder that stops early or updates its loss map wrongly is caught. A closed 2 × 2 square, with and without an extra solvable cell, separates a correct failure flag and zeroed output from partial repair. Further blocks add noise on the lost marker, stray bytes before the start of block, and random one-to-four cell losses, and each is compared with a map-only peeling model.

// File: rtl/cell_erasure_decoder.sv
module cell_erasure_decoder #(
  parameter int CELL_BYTES = 53,
  parameter int DIM        = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_sob,
  input  logic       in_erased,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       out_fail
);
  localparam int CELLS = DIM * DIM;
  localparam int DDIM  = DIM - 1;
  localparam int BW    = $clog2(CELL_BYTES);
  localparam int CW    = $clog2(CELLS);
  localparam int GW    = $clog2(DIM);

  function automatic logic [CELLS-1:0] data_mask();
    logic [CELLS-1:0] m;
    m = '0;
    for (int r = 0; r < DDIM; r++)
      for (int c = 0; c < DDIM; c++)
        m[r*DIM+c] = 1'b1;
    return m;
  endfunction
  localparam logic [CELLS-1:0] DMASK = data_mask();

  function automatic int cidx(int ln, int k, logic cm);
    return cm ? k * DIM + ln : ln * DIM + k;
  endfunction

  typedef enum logic [1:0] {S_LOAD, S_DEC, S_OUT} st_t;
  st_t state;

  logic [7:0]       mem [CELLS][CELL_BYTES];
  logic [7:0]       nxt [CELLS][CELL_BYTES];
  logic [CELLS-1:0] emap, emap_nxt;
  logic [DIM-1:0]   lmask [DIM];
  logic [DIM-1:0]   fix;
  logic             col_mode, idle_prev, progress;
  logic             inblk, cur_erased, fail;
  logic [BW-1:0]    ib, wb, ob;
  logic [CW-1:0]    ic, wc, ocell;
  logic [GW-1:0]    odr, odc;
  logic             take, first, wr_er, fin_in, fin_out;

  assign in_ready  = (state == S_LOAD);
  assign take      = in_valid && in_ready && (inblk || in_sob);
  assign wc        = in_sob ? '0 : ic;
  assign wb        = in_sob ? '0 : ib;
  assign first     = (wb == '0);
  assign wr_er     = first ? in_erased : cur_erased;
  assign fin_in    = (int'(wc) == CELLS - 1) && (int'(wb) == CELL_BYTES - 1);

  assign ocell     = CW'(int'(odr) * DIM + int'(odc));
  assign out_valid = (state == S_OUT);
  assign out_data  = out_valid ? mem[ocell][ob] : 8'h00;
  assign fin_out   = (int'(odr) == DDIM - 1) && (int'(odc) == DDIM - 1) &&
                     (int'(ob) == CELL_BYTES - 1);
  assign out_last  = out_valid && fin_out;
  assign out_fail  = out_valid && fail;

  always_comb begin
    for (int ln = 0; ln < DIM; ln++) begin
      for (int k = 0; k < DIM; k++)
        lmask[ln][k] = emap[cidx(ln, k, col_mode)];
      fix[ln] = ($countones(lmask[ln]) == 1);
    end
  end

  always_comb begin
    nxt      = mem;
    emap_nxt = emap;
    for (int ln = 0; ln < DIM; ln++) begin
      for (int b = 0; b < CELL_BYTES; b++) begin
        automatic logic [7:0] par = 8'h00;
        for (int k = 0; k < DIM; k++)
          par = par ^ mem[cidx(ln, k, col_mode)][b];
        for (int k = 0; k < DIM; k++)
          if (fix[ln] && lmask[ln][k])
            nxt[cidx(ln, k, col_mode)][b] = par;
      end
      for (int k = 0; k < DIM; k++)
        emap_nxt[cidx(ln, k, col_mode)] = lmask[ln][k] & ~fix[ln];
    end
  end

  assign progress = |(emap & ~emap_nxt);

  always_ff @(posedge clk) begin
    if (state == S_LOAD && take)
      mem[wc][wb] <= wr_er ? 8'h00 : in_data;
    else if (state == S_DEC)
      mem <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_LOAD;
      emap       <= '0;
      col_mode   <= 1'b0;
      idle_prev  <= 1'b0;
      inblk      <= 1'b0;
      cur_erased <= 1'b0;
      fail       <= 1'b0;
      ib         <= '0;
      ic         <= '0;
      ob         <= '0;
      odr        <= '0;
      odc        <= '0;
    end else begin
      case (state)
        S_LOAD: if (take) begin
          if (first) begin
            emap[wc]   <= in_erased;
            cur_erased <= in_erased;
          end
          if (int'(wb) == CELL_BYTES - 1) begin
            ib <= '0;
            ic <= wc + 1'b1;
          end else begin
            ib <= wb + 1'b1;
            ic <= wc;
          end
          inblk <= 1'b1;
          if (fin_in) begin
            inblk     <= 1'b0;
            ic        <= '0;
            col_mode  <= 1'b0;
            idle_prev <= 1'b0;
            state     <= S_DEC;
          end
        end
        S_DEC: begin
          emap      <= emap_nxt;
          col_mode  <= ~col_mode;
          idle_prev <= ~progress;
          if ((emap_nxt == '0) || (!progress && idle_prev)) begin
            fail  <= |(emap_nxt & DMASK);
            ob    <= '0;
            odr   <= '0;
            odc   <= '0;
            state <= S_OUT;
          end
        end
        S_OUT: begin
          if (int'(ob) == CELL_BYTES - 1) begin
            ob <= '0;
            if (int'(odc) == DDIM - 1) begin
              odc <= '0;
              odr <= odr + 1'b1;
            end else begin
              odc <= odc + 1'b1;
            end
          end else begin
            ob <= ob + 1'b1;
          end
          if (fin_out) state <= S_LOAD;
        end
        default: state <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/cell_erasure_decoder_chk.sv
module cell_erasure_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_last,
  input logic out_fail
);
  assert_ready_low_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_last_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  assert_ready_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!out_valid && in_ready));
  assert_fail_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_fail));
endmodule

bind cell_erasure_decoder cell_erasure_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_valid(out_valid), .out_last(out_last), .out_fail(out_fail)
);

// File: tb/cell_erasure_decoder_tb.sv
module cell_erasure_decoder_tb;
  localparam int NB = 53;
  localparam int D  = 6;
  localparam int NC = D * D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sob = 1'b0, in_erased = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last, out_fail;
  logic [7:0] out_data;

  cell_erasure_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sob(in_sob), .in_erased(in_erased), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_fail(out_fail)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] blk [NC][NB];
  bit er [NC];
  logic [9:0] exp_q [$];
  string tag = "R4";
  bit blk_done = 0;

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic make_block();
    for (int c = 0; c < NC; c++) er[c] = 0;
    for (int r = 0; r < D-1; r++)
      for (int c = 0; c < D-1; c++)
        for (int b = 0; b < NB; b++) blk[r*D+c][b] = 8'($urandom);
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < D-1; r++) begin
        blk[r*D+D-1][b] = 8'h00;
        for (int c = 0; c < D-1; c++) blk[r*D+D-1][b] ^= blk[r*D+c][b];
      end
      for (int c = 0; c < D; c++) begin
        blk[(D-1)*D+c][b] = 8'h00;
        for (int r = 0; r < D-1; r++) blk[(D-1)*D+c][b] ^= blk[r*D+c][b];
      end
    end
  endtask

  task automatic push_expected();
    bit rem [NC];
    bit chg, fl;
    rem = er;
    do begin
      chg = 0;
      for (int dir = 0; dir < 2; dir++)
        for (int ln = 0; ln < D; ln++) begin
          int n = 0, pos = 0;
          for (int k = 0; k < D; k++) begin
            int ci = dir ? k*D+ln : ln*D+k;
            if (rem[ci]) begin n++; pos = ci; end
          end
          if (n == 1) begin rem[pos] = 0; chg = 1; end
        end
    end while (chg);
    fl = 0;
    for (int r = 0; r < D-1; r++)
      for (int c = 0; c < D-1; c++) if (rem[r*D+c]) fl = 1;
    for (int r = 0; r < D-1; r++)
      for (int c = 0; c < D-1; c++)
        for (int b = 0; b < NB; b++) begin
          bit lst = (r == D-2) && (c == D-2) && (b == NB-1);
          exp_q.push_back({lst, fl, rem[r*D+c] ? 8'h00 : blk[r*D+c][b]});
        end
  endtask

  task automatic send_block(string t, bit noise, int junk);
    int lat = 0;
    tag = t;
    blk_done = 0;
    push_expected();
    for (int j = 0; j < junk; j++) begin
      @(negedge clk);
      in_valid = 1; in_sob = 0; in_erased = 1; in_data = 8'($urandom);
    end
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) begin
        @(negedge clk);
        in_valid  = 1;
        in_sob    = (c == 0 && b == 0);
        in_erased = (b == 0) ? er[c] : (noise ? ~er[c] : er[c]);
        in_data   = er[c] ? 8'($urandom) : blk[c][b];
      end
    @(negedge clk);
    in_valid = 0; in_sob = 0; in_erased = 0;
    check(!in_ready, "R9", in_ready, 0);
    while (!out_valid && lat < 200) begin
      lat++;
      @(negedge clk);
      if (!out_valid) check(!in_ready, "R9", in_ready, 0);
    end
    check(lat <= 81, "R10", lat, 81);
    wait (blk_done);
    @(negedge clk);
    check(in_ready && !out_valid, "R9", {in_ready, out_valid}, 2);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R8", out_data, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check(out_data == e[7:0], tag, out_data, e[7:0]);
        check(out_fail == e[8], "R7", out_fail, e[8]);
        check(out_last == e[9], "R8", out_last, e[9]);
        check(!in_ready, "R9", in_ready, 0);
      end
      if (out_last) blk_done = 1;
    end
  end

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid, "R1", {in_ready, out_valid}, 2);
    rst_n = 1;
    @(negedge clk);
    check(in_ready && !out_valid, "R1", {in_ready, out_valid}, 2);

    make_block(); send_block("R4", 0, 0);
    make_block(); er[2*D+3] = 1; send_block("R5", 0, 0);
    make_block(); er[5*D+1] = 1; er[0] = 1; send_block("R5", 0, 0);
    make_block(); er[0] = 1; er[1] = 1; er[D] = 1; send_block("R6", 0, 0);
    make_block();
    er[0] = 1; er[1] = 1; er[D+1] = 1; er[D+2] = 1; er[2*D+2] = 1;
    er[2*D+3] = 1; er[3*D+3] = 1; er[3*D+5] = 1; er[5*D+5] = 1;
    send_block("R6", 0, 0);
    make_block(); er[D+1] = 1; er[D+3] = 1; er[3*D+1] = 1; er[3*D+3] = 1;
    send_block("R7", 0, 0);
    make_block(); er[D+1] = 1; er[D+3] = 1; er[3*D+1] = 1; er[3*D+3] = 1;
    er[4*D] = 1; send_block("R7", 0, 0);
    make_block(); er[4*D+4] = 1; send_block("R3", 1, 0);
    make_block(); er[2*D] = 1; send_block("R2", 0, 7);
    for (int n = 0; n < 12; n++) begin
      int k;
      make_block();
      k = 1 + int'($urandom_range(3));
      for (int i = 0; i < k; i++) er[$urandom_range(NC-1)] = 1;
      send_block("R6", 0, 0);
    end
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule